// File: doc/BRIEF.md
# Floating-Point Coprocessor Instruction Decoder with Status Register

This block is the front end of a floating-point coprocessor attached to a 16-bit minicomputer. It takes one 16-bit instruction word per valid cycle and registers it. During the following cycle it presents the split fields of the word: class opcode, accumulator select, addressing mode and register number. In the same cycle it gives the instruction group, a compact operation code and an illegal-instruction flag. There are three groups: stack-based four-function arithmetic, mode setting and condition copy, and general operate.

The block also holds the floating status word, including its double-precision and long-integer flags. Mode-setting words and the load-status instruction update that word. A condition-copy instruction moves its low four bits into the CPU condition flags, and a store-status instruction drives it onto a result bus. The operand size reported for each instruction depends on the precision mode held at the moment the instruction is decoded. The arithmetic datapath and memory access lie outside this block.

Top module: `fpu_ctl_decode`

## Requirements
- R1: A word presented with `in_valid` high is registered at the next rising edge. For exactly the following cycle, `strobe` is high and `cls_opcode` = word & 0177700 (octal), `acc_sel` = word[7:6], `addr_mode` = word[5:3] and `reg_num` = word[2:0]. Without `in_valid`, `strobe` is low in the following cycle.
- R2: While `strobe` is high, exactly one of `grp_stack`, `grp_mode`, `grp_oper` and `illegal` is high.
- R3: Word[15:3] equal to octal 07500, 07501, 07502 or 07503 decodes to the stack group with `op_sel` 1 (add), 2 (subtract), 3 (multiply) or 4 (divide). Every other word in class 075000 is illegal.
- R4: In the mode group, the exact words 0170000, 0170001, 0170011, 0170002 and 0170012 give `op_sel` 5 (condition copy), 6 (clear double), 7 (set double), 8 (clear long) and 9 (set long). Any other word of class 0170000 is illegal.
- R5: After reset, `fps` is 0000300 (octal), which sets both the double flag (bit 7, `dbl_mode`) and the long flag (bit 6, `lng_mode`).
- R6: Class 0170100 is load-status (`op_sel` 10). On the edge that ends its strobe, `fps` takes the `in_src` value that was registered with the word, and `dbl_mode`/`lng_mode` follow its bits 7 and 6.
- R7: During a condition-copy strobe, `psw_we` is 1 and `psw_out` = {`psw_in`[15:4], `fps`[3:0]}. At all other times `psw_we` is 0 and `psw_out` = `psw_in`.
- R8: Class 0170200 is store-status (`op_sel` 11). During its strobe, `res_we` is 1 and `res_bus` = `fps`, and `fps` is unchanged afterwards. Otherwise `res_we` is 0 and `res_bus` is 0.
- R9: The single-operand classes 0170300, 0170400, 0170500, 0170600 and 0170700 give `op_sel` 12 to 16. Any word not matched by class is decoded with mask 0177400: 0171000, 0171400, 0172000, 0172400, 0173000, 0173400, 0174000, 0174400, 0175000, 0175400, 0176000, 0176400, 0177000 and 0177400 give `op_sel` 17 to 30 in that order.
- R10: A word that matches no encoding gives `illegal`=1, `op_sel`=0 and `opnd_bytes`=0. It causes no status, condition or result write.
- R11: `opnd_bytes` uses the mode held during the strobe. Float-format ops (13 to 24) give 8 if double, otherwise 4. Ops 10, 11, 25 and 28 give 2. Ops 26 and 29 give 4 if long, otherwise 2. Ops 27 and 30 give 4. All other ops give 0.
- R12: Mode and status updates take effect on the edge that ends the strobe, so the next instruction already sees them. Ops 6 to 9 clear or set only bit 7 or bit 6. Every other instruction and every idle cycle leaves `fps` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction word present |
| in_word | input | 16 | Instruction word |
| in_src | input | 16 | Source operand for load-status, taken with the word |
| psw_in | input | 16 | Current CPU status word |
| strobe | output | 1 | Decoded instruction valid (one cycle) |
| cls_opcode | output | 16 | Word & 0177700 |
| acc_sel | output | 2 | Accumulator select |
| addr_mode | output | 3 | Addressing mode |
| reg_num | output | 3 | Register number |
| grp_stack | output | 1 | Stack four-function group |
| grp_mode | output | 1 | Mode-set / condition-copy group |
| grp_oper | output | 1 | General operate group |
| illegal | output | 1 | Unknown encoding |
| op_sel | output | 5 | Compact operation code |
| opnd_bytes | output | 4 | Operand size in bytes |
| fps | output | 16 | Floating status word |
| dbl_mode | output | 1 | Double-precision flag |
| lng_mode | output | 1 | Long-integer flag |
| psw_out | output | 16 | CPU status word with copied conditions |
| psw_we | output | 1 | CPU status write |
| res_bus | output | 16 | Store-status result |
| res_we | output | 1 | Result valid |

## Verification
A status-changing instruction and the next instruction's decode fall in the same cycle. The edge that writes the new mode or status is also the edge that registers the following word. The bench issues set-double, clear-long and load-status words back to back with float, integer-conversion, condition-copy and store-status words. It judges the size, the copied condition bits and the stored word against a model in which the update is already visible. Random streams with idle gaps keep mode changes running continuously against every decoded class.

// File: rtl/fpu_dec_pkg.sv
package fpu_dec_pkg;
   typedef enum logic [4:0] {
      OP_NONE  = 5'd0,  OP_SADD  = 5'd1,  OP_SSUB  = 5'd2,  OP_SMUL  = 5'd3,
      OP_SDIV  = 5'd4,  OP_CCOPY = 5'd5,  OP_SGL   = 5'd6,  OP_DBL   = 5'd7,
      OP_SHRT  = 5'd8,  OP_LONG  = 5'd9,  OP_LDST  = 5'd10, OP_STST  = 5'd11,
      OP_STXS  = 5'd12, OP_CLR   = 5'd13, OP_TST   = 5'd14, OP_ABS   = 5'd15,
      OP_NEG   = 5'd16, OP_MUL   = 5'd17, OP_MOD   = 5'd18, OP_ADD   = 5'd19,
      OP_LD    = 5'd20, OP_SUB   = 5'd21, OP_CMP   = 5'd22, OP_ST    = 5'd23,
      OP_DIV   = 5'd24, OP_STX   = 5'd25, OP_CVTI  = 5'd26, OP_CVSF  = 5'd27,
      OP_LDX   = 5'd28, OP_LDI   = 5'd29, OP_LDSF  = 5'd30
   } op_e;
endpackage

// File: rtl/fpu_dec_field.sv
module fpu_dec_field
   import fpu_dec_pkg::*;
#(
   parameter int W      = 16,
   parameter bit STK_EN = 1'b1
) (
   input  logic [W-1:0] word,
   output op_e          op,
   output logic         grp_stack,
   output logic         grp_mode,
   output logic         grp_oper
);
   localparam logic [W-1:0] CLS_MASK = W'(16'o177700);
   localparam logic [W-1:0] SUB_MASK = W'(16'o177400);

   logic [W-1:0] cls;
   op_e          stk_op;
   op_e          gen_op;

   assign cls = word & CLS_MASK;

   generate
      if (STK_EN) begin : g_stack
         always_comb begin
            case (word[W-1:3])
               13'o07500: stk_op = OP_SADD;
               13'o07501: stk_op = OP_SSUB;
               13'o07502: stk_op = OP_SMUL;
               13'o07503: stk_op = OP_SDIV;
               default:   stk_op = OP_NONE;
            endcase
         end
      end else begin : g_nostack
         assign stk_op = OP_NONE;
      end
   endgenerate

   always_comb begin
      gen_op = OP_NONE;
      case (cls)
         16'o170000: begin
            case (word)
               16'o170000: gen_op = OP_CCOPY;
               16'o170001: gen_op = OP_SGL;
               16'o170011: gen_op = OP_DBL;
               16'o170002: gen_op = OP_SHRT;
               16'o170012: gen_op = OP_LONG;
               default:    gen_op = OP_NONE;
            endcase
         end
         16'o170100: gen_op = OP_LDST;
         16'o170200: gen_op = OP_STST;
         16'o170300: gen_op = OP_STXS;
         16'o170400: gen_op = OP_CLR;
         16'o170500: gen_op = OP_TST;
         16'o170600: gen_op = OP_ABS;
         16'o170700: gen_op = OP_NEG;
         default: begin
            case (word & SUB_MASK)
               16'o171000: gen_op = OP_MUL;
               16'o171400: gen_op = OP_MOD;
               16'o172000: gen_op = OP_ADD;
               16'o172400: gen_op = OP_LD;
               16'o173000: gen_op = OP_SUB;
               16'o173400: gen_op = OP_CMP;
               16'o174000: gen_op = OP_ST;
               16'o174400: gen_op = OP_DIV;
               16'o175000: gen_op = OP_STX;
               16'o175400: gen_op = OP_CVTI;
               16'o176000: gen_op = OP_CVSF;
               16'o176400: gen_op = OP_LDX;
               16'o177000: gen_op = OP_LDI;
               16'o177400: gen_op = OP_LDSF;
               default:    gen_op = OP_NONE;
            endcase
         end
      endcase
   end

   assign op        = (stk_op != OP_NONE) ? stk_op : gen_op;
   assign grp_stack = (op >= OP_SADD)  && (op <= OP_SDIV);
   assign grp_mode  = (op >= OP_CCOPY) && (op <= OP_LONG);
   assign grp_oper  = (op >= OP_LDST);

   always_comb begin
      a_r3_stack_class : assert (!grp_stack || (cls == W'(16'o075000)));
   end
endmodule

// File: rtl/fpu_dec_status.sv
module fpu_dec_status
   import fpu_dec_pkg::*;
#(
   parameter int          W       = 16,
   parameter logic [15:0] RST_VAL = 16'o000300,
   parameter int          DBL_POS = 7,
   parameter int          LNG_POS = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         upd_en,
   input  op_e          op,
   input  logic [W-1:0] ld_data,
   output logic [W-1:0] fps
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fps <= W'(RST_VAL);
      end else if (upd_en) begin
         case (op)
            OP_SGL:  fps[DBL_POS] <= 1'b0;
            OP_DBL:  fps[DBL_POS] <= 1'b1;
            OP_SHRT: fps[LNG_POS] <= 1'b0;
            OP_LONG: fps[LNG_POS] <= 1'b1;
            OP_LDST: fps          <= ld_data;
            default: ;
         endcase
      end
   end

   a_r12_idle_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> fps == $past(fps));
   a_r12_other_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !(op inside {OP_SGL, OP_DBL, OP_SHRT, OP_LONG, OP_LDST}))
      |=> fps == $past(fps));
   a_r6_load : assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && op == OP_LDST) |=> fps == $past(ld_data));
   a_r12_set_dbl : assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && op == OP_DBL) |=> fps[DBL_POS]);
endmodule

// File: rtl/fpu_dec_size.sv
module fpu_dec_size
   import fpu_dec_pkg::*;
(
   input  op_e        op,
   input  logic       dbl,
   input  logic       lng,
   output logic [3:0] nbytes
);
   always_comb begin
      case (op)
         OP_CLR, OP_TST, OP_ABS, OP_NEG, OP_MUL, OP_MOD, OP_ADD, OP_LD,
         OP_SUB, OP_CMP, OP_ST, OP_DIV:
            nbytes = dbl ? 4'd8 : 4'd4;
         OP_LDST, OP_STST, OP_STX, OP_LDX:
            nbytes = 4'd2;
         OP_CVTI, OP_LDI:
            nbytes = lng ? 4'd4 : 4'd2;
         OP_CVSF, OP_LDSF:
            nbytes = 4'd4;
         default:
            nbytes = 4'd0;
      endcase
   end
endmodule

// File: rtl/fpu_ctl_decode.sv
module fpu_ctl_decode
   import fpu_dec_pkg::*;
#(
   parameter int          W       = 16,
   parameter int          CC_W    = 4,
   parameter bit          STK_EN  = 1'b1,
   parameter logic [15:0] RST_FPS = 16'o000300
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [15:0]   in_word,
   input  logic [15:0]   in_src,
   input  logic [15:0]   psw_in,
   output logic          strobe,
   output logic [15:0]   cls_opcode,
   output logic [1:0]    acc_sel,
   output logic [2:0]    addr_mode,
   output logic [2:0]    reg_num,
   output logic          grp_stack,
   output logic          grp_mode,
   output logic          grp_oper,
   output logic          illegal,
   output logic [4:0]    op_sel,
   output logic [3:0]    opnd_bytes,
   output logic [15:0]   fps,
   output logic          dbl_mode,
   output logic          lng_mode,
   output logic [15:0]   psw_out,
   output logic          psw_we,
   output logic [15:0]   res_bus,
   output logic          res_we
);
   localparam int DBL_POS = 7;
   localparam int LNG_POS = 6;

   generate
      if (W != 16) begin : g_bad_w
         $error("fpu_ctl_decode: instruction layout needs W == 16");
      end
      if (CC_W < 1 || CC_W >= W) begin : g_bad_cc
         $error("fpu_ctl_decode: CC_W out of range");
      end
   endgenerate

   logic         st_v;
   logic [15:0]  st_word;
   logic [15:0]  st_src;
   op_e          op;
   logic [3:0]   nbytes;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_v    <= 1'b0;
         st_word <= '0;
         st_src  <= '0;
      end else begin
         st_v <= in_valid;
         if (in_valid) begin
            st_word <= in_word;
            st_src  <= in_src;
         end
      end
   end

   fpu_dec_field #(.W(W), .STK_EN(STK_EN)) i_field (
      .word      (st_word),
      .op        (op),
      .grp_stack (grp_stack),
      .grp_mode  (grp_mode),
      .grp_oper  (grp_oper)
   );

   fpu_dec_status #(.W(W), .RST_VAL(RST_FPS), .DBL_POS(DBL_POS),
                    .LNG_POS(LNG_POS)) i_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_en  (st_v),
      .op      (op),
      .ld_data (st_src),
      .fps     (fps)
   );

   assign dbl_mode = fps[DBL_POS];
   assign lng_mode = fps[LNG_POS];

   fpu_dec_size i_size (
      .op     (op),
      .dbl    (dbl_mode),
      .lng    (lng_mode),
      .nbytes (nbytes)
   );

   assign strobe     = st_v;
   assign cls_opcode = st_word & 16'o177700;
   assign acc_sel    = st_word[7:6];
   assign addr_mode  = st_word[5:3];
   assign reg_num    = st_word[2:0];
   assign op_sel     = op;
   assign illegal    = (op == OP_NONE);
   assign opnd_bytes = nbytes;

   assign psw_we  = st_v && (op == OP_CCOPY);
   assign psw_out = psw_we ? {psw_in[15:CC_W], fps[CC_W-1:0]} : psw_in;
   assign res_we  = st_v && (op == OP_STST);
   assign res_bus = res_we ? fps : '0;

   a_r1_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> strobe);
   a_r1_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !strobe);
   a_r2_one_group : assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> $onehot({grp_stack, grp_mode, grp_oper, illegal}));
   a_r8_store_keeps : assert property (@(posedge clk) disable iff (!rst_n)
      res_we |=> fps == $past(fps));
   a_r10_no_write : assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && illegal) |-> (!psw_we && !res_we && opnd_bytes == 4'd0));
   a_r10_fps_keep : assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && illegal) |=> fps == $past(fps));
   a_r7_cc_copy : assert property (@(posedge clk) disable iff (!rst_n)
      psw_we |-> (psw_out[CC_W-1:0] == fps[CC_W-1:0] && strobe));
endmodule

// File: tb/test_fpu_ctl_decode.sv
module test_fpu_ctl_decode;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_word = '0;
   logic [15:0] in_src = '0;
   logic [15:0] psw_in = '0;
   logic        strobe, grp_stack, grp_mode, grp_oper, illegal;
   logic [15:0] cls_opcode, fps, psw_out, res_bus;
   logic [1:0]  acc_sel;
   logic [2:0]  addr_mode, reg_num;
   logic [4:0]  op_sel;
   logic [3:0]  opnd_bytes;
   logic        dbl_mode, lng_mode, psw_we, res_we;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   fpu_ctl_decode i_fpu_ctl_decode (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .in_src(in_src), .psw_in(psw_in), .strobe(strobe),
      .cls_opcode(cls_opcode), .acc_sel(acc_sel), .addr_mode(addr_mode),
      .reg_num(reg_num), .grp_stack(grp_stack), .grp_mode(grp_mode),
      .grp_oper(grp_oper), .illegal(illegal), .op_sel(op_sel),
      .opnd_bytes(opnd_bytes), .fps(fps), .dbl_mode(dbl_mode),
      .lng_mode(lng_mode), .psw_out(psw_out), .psw_we(psw_we),
      .res_bus(res_bus), .res_we(res_we));

   function automatic int exp_op(input logic [15:0] w);
      logic [15:0] c;
      c = w & 16'o177700;
      case (w[15:3])
         13'o07500: return 1;
         13'o07501: return 2;
         13'o07502: return 3;
         13'o07503: return 4;
         default: ;
      endcase
      if (c == 16'o170000) begin
         case (w)
            16'o170000: return 5;
            16'o170001: return 6;
            16'o170011: return 7;
            16'o170002: return 8;
            16'o170012: return 9;
            default: return 0;
         endcase
      end
      if (c >= 16'o170100 && c <= 16'o170700) return 10 + int'((c - 16'o170100) >> 6);
      if ((w & 16'o177400) >= 16'o171000)
         return 17 + int'(((w & 16'o177400) - 16'o171000) >> 8);
      return 0;
   endfunction

   function automatic int exp_bytes(input int op, input logic [15:0] f);
      if (op >= 13 && op <= 24) return f[7] ? 8 : 4;
      if (op == 10 || op == 11 || op == 25 || op == 28) return 2;
      if (op == 26 || op == 29) return f[6] ? 4 : 2;
      if (op == 27 || op == 30) return 4;
      return 0;
   endfunction

   function automatic int exp_grp(input int op);
      if (op == 0) return 4'b0001;
      if (op <= 4) return 4'b1000;
      if (op <= 9) return 4'b0100;
      return 4'b0010;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
      end
   endtask

   logic [15:0] m_fps;
   bit          pend_v;
   logic [15:0] pend_w, pend_s;

   // check the instruction registered at the previous edge, then update the model
   task automatic check_cycle();
      int op;
      if (!pend_v) begin
         chk(strobe == 1'b0, "R1 idle strobe", 32'(strobe), 0);
         chk(fps == m_fps, "R12 idle fps", 32'(fps), 32'(m_fps));
         chk(!psw_we && psw_out == psw_in, "R7 idle psw", 32'(psw_out), 32'(psw_in));
         return;
      end
      op = exp_op(pend_w);
      chk(strobe == 1'b1, "R1 strobe", 32'(strobe), 1);
      chk({cls_opcode, acc_sel, addr_mode, reg_num} ==
          {pend_w & 16'o177700, pend_w[7:6], pend_w[5:3], pend_w[2:0]},
          "R1 fields", {cls_opcode, acc_sel, addr_mode, reg_num},
          {pend_w & 16'o177700, pend_w[7:6], pend_w[5:3], pend_w[2:0]});
      chk(int'(op_sel) == op, (op <= 4) ? "R3 op" : (op <= 9) ? "R4 op" : "R9 op",
          32'(op_sel), 32'(op));
      chk(int'({grp_stack, grp_mode, grp_oper, illegal}) == exp_grp(op),
          (op == 0) ? "R10 group" : "R2 group",
          32'({grp_stack, grp_mode, grp_oper, illegal}), 32'(exp_grp(op)));
      chk(fps == m_fps, "R12 fps before", 32'(fps), 32'(m_fps));
      chk(int'(opnd_bytes) == exp_bytes(op, m_fps), "R11 bytes",
          32'(opnd_bytes), 32'(exp_bytes(op, m_fps)));
      if (op == 5)
         chk(psw_we && psw_out == {psw_in[15:4], m_fps[3:0]}, "R7 copy",
             {15'd0, psw_we, psw_out}, {16'd1, psw_in[15:4], m_fps[3:0]});
      else
         chk(!psw_we && psw_out == psw_in, "R7 no copy",
             {15'd0, psw_we, psw_out}, {16'd0, psw_in});
      if (op == 11)
         chk(res_we && res_bus == m_fps, "R8 store", {15'd0, res_we, res_bus},
             {16'd1, m_fps});
      else
         chk(!res_we && res_bus == 16'd0, "R8 no store", {15'd0, res_we, res_bus}, 0);
      case (op)
         6:  m_fps[7] = 1'b0;
         7:  m_fps[7] = 1'b1;
         8:  m_fps[6] = 1'b0;
         9:  m_fps[6] = 1'b1;
         10: m_fps = pend_s;
         default: ;
      endcase
   endtask

   task automatic step(input bit v, input logic [15:0] w, input logic [15:0] s);
      @(negedge clk);
      check_cycle();
      in_valid = v;
      in_word  = w;
      in_src   = s;
      psw_in   = 16'($urandom);
      pend_v   = v;
      pend_w   = w;
      pend_s   = s;
   endtask

   function automatic logic [15:0] rand_word();
      logic [15:0] r;
      r = 16'($urandom);
      case ($urandom % 7)
         0: return r;
         1: return 16'o075000 | {10'd0, r[5:0]};
         2: return 16'o170000 | {12'd0, r[3:0]};
         3: return 16'o170000 | {10'd0, 6'(($urandom % 3) * 8 + 1)} + 16'(r[0]);
         4: return 16'o170000 | {7'd0, r[8:0]};
         default: return 16'o170000 | {4'd0, r[11:0]};
      endcase
   endfunction

   initial begin
      void'($urandom(32'd24681));
      pend_v = 1'b0;
      m_fps  = 16'o000300;
      repeat (3) @(negedge clk);
      chk(fps == 16'o000300 && dbl_mode && lng_mode, "R5 reset fps", 32'(fps), 32'o300);
      chk(strobe == 1'b0, "R1 reset strobe", 32'(strobe), 0);
      rst_n = 1'b1;
      // directed: mode changes back to back with size-dependent ops (R11, R12)
      step(1, 16'o172012, 0);          // ADD, double -> 8
      step(1, 16'o170001, 0);          // clear double
      step(1, 16'o172012, 0);          // ADD, now 4
      step(1, 16'o170011, 0);          // set double
      step(1, 16'o170500, 0);          // TST, 8
      step(1, 16'o170002, 0);          // clear long
      step(1, 16'o177001, 0);          // LDI, 2
      step(1, 16'o170012, 0);          // set long
      step(1, 16'o175400, 0);          // CVTI, 4
      // R6 load then immediate R7 copy and R8 store
      step(1, 16'o170127, 16'o000017);
      step(1, 16'o170000, 0);
      step(1, 16'o170200, 0);
      step(1, 16'o172400, 0);          // LD with single mode
      step(1, 16'o170100, 16'o000305);
      step(1, 16'o170200, 0);
      // R3 stack group and its boundaries, R10 illegal
      step(1, 16'o075000, 0);
      step(1, 16'o075017, 0);
      step(1, 16'o075027, 0);
      step(1, 16'o075037, 0);
      step(1, 16'o075040, 0);
      step(1, 16'o170003, 0);
      step(1, 16'o170013, 0);
      step(1, 16'o170777, 0);
      step(1, 16'o177777, 0);
      step(1, 16'o171000, 0);
      step(1, 16'o000000, 0);
      step(0, 16'o170011, 0);
      // random stream with idle gaps
      for (int i = 0; i < 3000; i++) begin
         if ($urandom % 5 == 0) step(0, 16'($urandom), 16'($urandom));
         else step(1, rand_word(), 16'($urandom));
      end
      step(0, 0, 0);
      step(0, 0, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #2000000;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule